// File: doc/BRIEF.md
# Equivalent-Time Reflectometer Sweep Sequencer

This block runs a time-domain reflectometer whose receiver is a single comparator. Each sweep steps the comparator threshold through every code of an 8-bit DAC. At each threshold the block sends one stimulus pulse and records the whole reflected waveform as one bit per time bin. The comparator is sampled on both clock edges, so every clock cycle gives two adjacent bins. The amplitude is refined across pulses, one threshold per pulse. Within a pulse the whole time axis is covered at once. This is the reverse of a successive-approximation converter, which settles one sample fully before it moves to the next.

The threshold begins at zero and rises by one code per pulse. Each new code goes to the DAC over a load/acknowledge handshake. A programmable settle time follows the acknowledge, and only then does the pulse fire. For every bin the block keeps the highest threshold at which the comparator still reported a 1. After the final code a done flag rises, and software reads the finished trace through a synchronous read port. One time bin is about 10 cm of cable after the round trip.

Top module: `tdr_sweep`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `done`, `pulse` and `dac_load` are 0.
- R2: A `start` pulse when idle begins a sweep of exactly 256 pulses. Their threshold codes, as given to the DAC, are 0, 1, 2 … 255 in that order.
- R3: `dac_load` stays high and `dac_code` stays unchanged until `dac_ack` is sampled high. No pulse is fired while `dac_load` is high.
- R4: `pulse` is high for exactly one cycle. It rises on the (S+1)-th rising edge after the edge that samples `dac_ack` high, where S is the `settle_cycles` value captured at start.
- R5: Let E0 be the edge that raises `pulse`. At edge E(k+1) the block takes `cmp_rise` as bin 2k and `cmp_fall` as bin 2k+1, for k from 0 to BINS/2−1.
- R6: After a sweep, each bin holds the highest threshold code whose pulse captured a 1 in that bin. A bin that was never 1 holds 0.
- R7: `done` rises when the last capture at code 255 ends, and `busy` is then 0. A new start clears `done` and sets `busy` at the next edge.
- R8: `start` while busy is ignored. The sweep keeps its code order, its settle time and its pulse count.
- R9: `rd_data` gives the stored code of bin `rd_addr` one clock after the address is presented, with bin addresses 0 to BINS−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; comparator data is taken on both of its edges outside this block |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a sweep when idle |
| settle_cycles | input | SETTLE_W | Wait after each DAC acknowledge before the pulse, latched at start |
| dac_ack | input | 1 | DAC has taken `dac_code` |
| cmp_rise | input | 1 | Comparator bit taken at the rising edge (even bin) |
| cmp_fall | input | 1 | Comparator bit taken at the falling edge (odd bin) |
| rd_addr | input | $clog2(BINS) | Result bin to read |
| pulse | output | 1 | Stimulus strobe |
| dac_load | output | 1 | New threshold code is valid |
| dac_code | output | CODE_W | Threshold code for the DAC |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep complete, trace valid |
| rd_data | output | CODE_W | Stored amplitude of the addressed bin |

## Verification
Some properties hold at every clock edge, and the checker tests them there: the handshake holding the code steady, no pulse fired during a DAC load, single-cycle pulses, thresholds that never fall during a sweep, `done` only when idle, and start ignored while busy. The exact settle spacing, the mapping of the rise and fall samples to even and odd bins, and the reconstructed amplitude of each bin can only be shown by the bench. Its reflection profiles (random and directed, including 0 and full-scale bins) let it compute every expected code and compare it through the read port.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETTLE,
    ST_CAPT
  } seq_state_t;
endpackage

// File: rtl/tdr_seq.sv
module tdr_seq
  import tdr_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int SETTLE_W = 16,
  parameter int CAP_W    = 9,
  parameter int CAP_LEN  = 512
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                dac_ack,
  output logic                pulse,
  output logic                dac_load,
  output logic [CODE_W-1:0]   dac_code,
  output logic                busy,
  output logic                done,
  output logic                cap_en,
  output logic [CAP_W-1:0]    cap_idx
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CAP_W-1:0]  CAP_LAST = CAP_W'(CAP_LEN - 1);

  seq_state_t          state;
  logic [SETTLE_W-1:0] settle_q;
  logic [SETTLE_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      settle_q <= '0;
      wait_cnt <= '0;
      cap_idx  <= '0;
      dac_code <= '0;
      dac_load <= 1'b0;
      pulse    <= 1'b0;
      done     <= 1'b0;
    end else begin
      pulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            settle_q <= settle_cycles;
            dac_code <= '0;
            dac_load <= 1'b1;
            done     <= 1'b0;
            state    <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (dac_ack) begin
            dac_load <= 1'b0;
            wait_cnt <= settle_q;
            state    <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (wait_cnt == '0) begin
            pulse   <= 1'b1;
            cap_idx <= '0;
            state   <= ST_CAPT;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        ST_CAPT: begin
          cap_idx <= cap_idx + 1'b1;
          if (cap_idx == CAP_LAST) begin
            if (dac_code == CODE_MAX) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              dac_code <= dac_code + 1'b1;
              dac_load <= 1'b1;
              state    <= ST_LOAD;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign cap_en = (state == ST_CAPT);
endmodule

// File: rtl/tdr_bank.sv
module tdr_bank #(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tdr_sweep.sv
module tdr_sweep #(
  parameter int BINS     = 1024,
  parameter int CODE_W   = 8,
  parameter int SETTLE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [SETTLE_W-1:0]     settle_cycles,
  input  logic                    dac_ack,
  input  logic                    cmp_rise,
  input  logic                    cmp_fall,
  input  logic [$clog2(BINS)-1:0] rd_addr,
  output logic                    pulse,
  output logic                    dac_load,
  output logic [CODE_W-1:0]       dac_code,
  output logic                    busy,
  output logic                    done,
  output logic [CODE_W-1:0]       rd_data
);
  localparam int BIN_W   = $clog2(BINS);
  localparam int CAP_LEN = BINS / 2;
  localparam int CAP_W   = BIN_W - 1;

  logic             cap_en;
  logic [CAP_W-1:0] cap_idx;
  logic [1:0]       cmp_pair;
  logic             first_code;
  logic             sel_q;
  logic [CODE_W-1:0] bank_q [2];

  tdr_seq #(
    .CODE_W  (CODE_W),
    .SETTLE_W(SETTLE_W),
    .CAP_W   (CAP_W),
    .CAP_LEN (CAP_LEN)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .settle_cycles(settle_cycles),
    .dac_ack      (dac_ack),
    .pulse        (pulse),
    .dac_load     (dac_load),
    .dac_code     (dac_code),
    .busy         (busy),
    .done         (done),
    .cap_en       (cap_en),
    .cap_idx      (cap_idx)
  );

  assign cmp_pair   = {cmp_fall, cmp_rise};
  assign first_code = (dac_code == '0);

  // Bank 0 holds even bins (rising-edge samples), bank 1 odd bins.
  for (genvar g = 0; g < 2; g++) begin : g_bank
    tdr_bank #(
      .DEPTH(CAP_LEN),
      .AW   (CAP_W),
      .DW   (CODE_W)
    ) u_bank (
      .clk  (clk),
      .we   (cap_en && (cmp_pair[g] || first_code)),
      .waddr(cap_idx),
      .wdata(dac_code),
      .raddr(rd_addr[BIN_W-1:1]),
      .rdata(bank_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= rd_addr[0];
  end

  assign rd_data = sel_q ? bank_q[1] : bank_q[0];
endmodule

// File: rtl/tdr_sweep_chk.sv
module tdr_sweep_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              pulse,
  input logic              dac_load,
  input logic              dac_ack,
  input logic [CODE_W-1:0] dac_code,
  input logic              busy,
  input logic              done
);
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    dac_load && !dac_ack |=> dac_load && $stable(dac_code)); // R3
  AST_NO_PULSE_IN_LOAD: assert property (@(posedge clk) disable iff (rst)
    pulse |-> !dac_load); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse); // R4
  AST_CODE_RISES: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> dac_code >= $past(dac_code)); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    busy && start && !(dac_code == {CODE_W{1'b1}}) |=> busy && !done); // R8
endmodule

bind tdr_sweep tdr_sweep_chk #(.CODE_W(CODE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .pulse   (pulse),
  .dac_load(dac_load),
  .dac_ack (dac_ack),
  .dac_code(dac_code),
  .busy    (busy),
  .done    (done)
);

// File: tb/tdr_sweep_test.sv
module tdr_sweep_test;
  localparam int BINS  = 32;
  localparam int CW    = 8;
  localparam int SW    = 16;
  localparam int HALF  = BINS / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [SW-1:0] settle_cycles = '0;
  logic dac_ack = 1'b0;
  logic cmp_rise = 1'b0;
  logic cmp_fall = 1'b0;
  logic [$clog2(BINS)-1:0] rd_addr = '0;
  logic pulse, dac_load, busy, done;
  logic [CW-1:0] dac_code, rd_data;

  int checks = 0;
  int errors = 0;
  int amp [BINS];
  int thr = 0;
  int exp_code = 0;
  int npulse = 0;
  int cur_settle = 0;
  int ci = 1000;
  bit prev_pulse = 1'b0;
  int cycles = 0;

  tdr_sweep #(.BINS(BINS), .CODE_W(CW), .SETTLE_W(SW)) uut (
    .clk(clk), .rst(rst), .start(start), .settle_cycles(settle_cycles),
    .dac_ack(dac_ack), .cmp_rise(cmp_rise), .cmp_fall(cmp_fall),
    .rd_addr(rd_addr), .pulse(pulse), .dac_load(dac_load),
    .dac_code(dac_code), .busy(busy), .done(done), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  function automatic int expect_bin(int a);
    if (a <= 0) return 0;
    if (a >= 256) return 255;
    return a - 1;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  // comparator model: reflected level amp[b] exceeds threshold -> 1 (R5)
  always @(negedge clk) begin
    if (pulse) begin
      check(!prev_pulse, "R4 single-cycle pulse", 1, 0);
      ci = 0;
      npulse++;
    end else begin
      ci++;
    end
    prev_pulse = pulse;
    if (ci < HALF) begin
      cmp_rise = amp[2*ci] > thr;
      cmp_fall = amp[2*ci+1] > thr;
    end else begin
      cmp_rise = 1'b0;
      cmp_fall = 1'b0;
    end
  end

  // DAC model with random acknowledge delay
  initial begin
    forever begin
      @(negedge clk);
      if (dac_load && !rst) begin
        automatic int d = $urandom_range(0, 3);
        automatic logic [CW-1:0] held = dac_code;
        automatic int n = 0;
        for (int i = 0; i < d; i++) begin
          if (dac_code != held || pulse) check(1'b0, "R3 code held, no pulse", dac_code, held);
          @(negedge clk);
        end
        check(dac_code == CW'(exp_code), "R2 code order", dac_code, exp_code);
        exp_code++;
        thr = dac_code;
        dac_ack = 1'b1;
        forever begin
          @(negedge clk);
          n++;
          if (n == 1) dac_ack = 1'b0;
          if (pulse || n > 1000) break;
        end
        check(n == cur_settle + 2, "R4 settle spacing", n, cur_settle + 2);
      end
    end
  end

  task automatic sweep(int settle, bit poke);
    settle_cycles = SW'(settle);
    cur_settle = settle;
    exp_code = 0;
    npulse = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy && !done, "R7 start sets busy, clears done", {busy, done}, 2);
    if (poke) begin
      while (npulse < 100) @(negedge clk);
      settle_cycles = SW'(settle + 5);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      settle_cycles = SW'(settle);
      check(busy && !done, "R8 start ignored while busy", {busy, done}, 2);
    end
    while (!done) @(negedge clk);
    check(!busy, "R7 idle when done", busy, 0);
    @(negedge clk);
    check(npulse == 256, "R2 pulse count", npulse, 256);
    check(exp_code == 256, "R2 code count", exp_code, 256);
    check(!pulse && !dac_load, "R7 stays idle", {pulse, dac_load}, 0);
    // pipelined readback: address every cycle, data one cycle later (R9)
    rd_addr = '0;
    for (int i = 1; i <= BINS; i++) begin
      @(negedge clk);
      check(rd_data == CW'(expect_bin(amp[i-1])), "R5 R6 R9 bin value",
            rd_data, expect_bin(amp[i-1]));
      if (i < BINS) rd_addr = i[$clog2(BINS)-1:0];
    end
  endtask

  initial begin
    void'($urandom(32'd20140826));
    for (int b = 0; b < BINS; b++) amp[b] = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !pulse && !dac_load, "R1 in reset",
          {busy, done, pulse, dac_load}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !pulse && !dac_load, "R1 after reset",
          {busy, done, pulse, dac_load}, 0);

    // random profile, no settle
    for (int b = 0; b < BINS; b++) amp[b] = $urandom_range(0, 256);
    sweep(0, 1'b0);

    // directed corners: zero, full-scale, one LSB, even/odd contrast
    amp[0] = 0; amp[1] = 256; amp[2] = 1; amp[3] = 255; amp[4] = 2;
    for (int b = 5; b < BINS; b++) amp[b] = (b % 2 == 1) ? (b * 7) % 257 : 200 - b;
    sweep(3, 1'b1);

    // random profile again, longer settle
    for (int b = 0; b < BINS; b++) amp[b] = $urandom_range(0, 256);
    sweep(7, 1'b0);

    finish_run();
  end
endmodule